// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes a data word between two buses, A and B, in either direction. Each direction owns a storage register with its own clock. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. On the side that is driven, a select picks one of two sources: the live word on the opposite bus or the word held in that direction's register. An active-low enable and a direction input together choose which single bus the block drives, or whether it drives neither.

Each bus is split into an input vector, an output vector and an output-enable bit, so that a tri-state pad ring can be added around the block. Every output path is combinational from the controls, the live inputs and the register contents. The registers keep sampling on every rising edge of their clocks, whatever the enable and direction inputs are doing. This lets a word be captured while the block is isolated and sent out later.

Top module: `bxr_transceiver`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_ab` low, the A-to-B register loads `a_in`, for any value of `oe_n`, `dir` and the selects.
- R2: On each rising edge of `clk_ba` with `rst_ba` low, the B-to-A register loads `b_in`, for any value of `oe_n`, `dir` and the selects.
- R3: An edge on one register clock leaves the other register's contents unchanged.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R5: While `oe_n` is 0, `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0. `a_oe` and `b_oe` are never 1 together.
- R6: `a_out` equals `b_in` when `sel_ba` = 0, and equals the B-to-A register when `sel_ba` = 1. In stored mode a change on `b_in` has no effect on `a_out`.
- R7: `b_out` equals `a_in` when `sel_ab` = 0, and equals the A-to-B register when `sel_ab` = 1.
- R8: A rising clock edge with that register's reset high clears the register to zero. The other register is unaffected.
- R9: A change on a select line or a live input reaches `a_out`/`b_out` with no clock edge.
- R10: `a_out` and `b_out` carry their selected word even while their enable is 0, so the register contents can be observed while the block is isolated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Clock of the A-to-B register |
| rst_ab | input | 1 | Synchronous active-high clear of the A-to-B register |
| clk_ba | input | 1 | Clock of the B-to-A register |
| rst_ba | input | 1 | Synchronous active-high clear of the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 0 drives the A bus, 1 drives the B bus |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored B |
| a_in | input | WIDTH | Word seen on the A bus |
| a_out | output | WIDTH | Word the block offers to the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | WIDTH | Word seen on the B bus |
| b_out | output | WIDTH | Word the block offers to the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The enables and the outputs in live mode depend on no register, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling clock edge and samples these results one nanosecond later, with no clock edge in between. A stored word is due after the single rising edge of its own clock. The bench opens a register's clock for exactly one edge at a time, so it controls which register samples. It then reads the register through the stored-mode select at the next falling edge.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    function automatic drive_e drive_pick(input logic oe_n, input logic dir);
        if (oe_n)     return DRV_NONE;
        else if (dir) return DRV_B;
        else          return DRV_A;
    endfunction
endpackage

// File: rtl/bxr_store_reg.sv
module bxr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = d;
        if (rst) st_d.word = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.word;

    // R8: reset edge leaves zero behind
    a_r8_clear: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/bxr_out_mux.sv
module bxr_out_mux #(
    parameter int WIDTH = 8
) (
    input  logic             sel_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = sel_stored ? stored[i] : live[i];
    end
endmodule

// File: rtl/bxr_drive_ctl.sv
module bxr_drive_ctl
    import bxr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);
    drive_e drv;

    always_comb begin
        drv  = drive_pick(oe_n, dir);
        a_oe = (drv == DRV_A);
        b_oe = (drv == DRV_B);
    end
endmodule

// File: rtl/bxr_transceiver.sv
module bxr_transceiver #(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             rst_ab,
    input  logic             clk_ba,
    input  logic             rst_ba,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [WIDTH-1:0] ab_word;
    logic [WIDTH-1:0] ba_word;

    bxr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(clk_ab), .rst(rst_ab), .d(a_in), .q(ab_word)
    );

    bxr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(clk_ba), .rst(rst_ba), .d(b_in), .q(ba_word)
    );

    bxr_out_mux #(.WIDTH(WIDTH)) u_mux_b (
        .sel_stored(sel_ab), .live(a_in), .stored(ab_word), .y(b_out)
    );

    bxr_out_mux #(.WIDTH(WIDTH)) u_mux_a (
        .sel_stored(sel_ba), .live(b_in), .stored(ba_word), .y(a_out)
    );

    bxr_drive_ctl u_drive (
        .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
    );

    // R1: A-to-B register follows the A bus
    a_r1_capture_ab: assert property (@(posedge clk_ab) disable iff (rst_ab)
        1'b1 |=> (ab_word == $past(a_in)));
    // R2: B-to-A register follows the B bus
    a_r2_capture_ba: assert property (@(posedge clk_ba) disable iff (rst_ba)
        1'b1 |=> (ba_word == $past(b_in)));
    // R4: isolation drives nothing
    a_r4_isolate: assert property (@(posedge clk_ab) disable iff (rst_ab)
        oe_n |-> (!a_oe && !b_oe));
    // R5: never both buses
    a_r5_one_bus: assert property (@(posedge clk_ab) disable iff (rst_ab)
        !(a_oe && b_oe));
    // R7: stored A word on driven B bus
    a_r7_stored_b: assert property (@(posedge clk_ab) disable iff (rst_ab)
        (!oe_n && dir && sel_ab) |-> (b_oe && b_out == ab_word));
    // R6: stored B word on driven A bus
    a_r6_stored_a: assert property (@(posedge clk_ba) disable iff (rst_ba)
        (!oe_n && !dir && sel_ba) |-> (a_oe && a_out == ba_word));
endmodule

// File: tb/tb_bxr_transceiver.sv
`timescale 1ns/1ps
module tb_bxr_transceiver;
    localparam int W = 8;

    logic clk = 1'b0;
    logic en_ab, en_ba;
    logic clk_ab, clk_ba;
    logic rst_ab, rst_ba, oe_n, dir, sel_ab, sel_ba;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    assign clk_ab = clk & en_ab;
    assign clk_ba = clk & en_ba;

    bxr_transceiver #(.WIDTH(W)) dut (
        .clk_ab(clk_ab), .rst_ab(rst_ab), .clk_ba(clk_ba), .rst_ba(rst_ba),
        .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic do_ab, input logic do_ba);
        @(negedge clk);
        en_ab = do_ab;
        en_ba = do_ba;
        @(posedge clk);
        @(negedge clk);
        en_ab = 1'b0;
        en_ba = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        oe_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1; #1;
        chk("R4 a_oe isolated", {7'd0, a_oe}, 8'h00);
        chk("R4 b_oe isolated", {7'd0, b_oe}, 8'h00);
        chk("R8 ab cleared (R10)", b_out, 8'h00);
        chk("R8 ba cleared (R10)", a_out, 8'h00);
    endtask

    task automatic t_live_ab();
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h3C; #1;
        chk("R5 b_oe dir=1", {7'd0, b_oe}, 8'h01);
        chk("R5 a_oe dir=1", {7'd0, a_oe}, 8'h00);
        chk("R7 live A to B", b_out, 8'h3C);
        a_in = 8'hC3; #1;
        chk("R9 live A change", b_out, 8'hC3);
    endtask

    task automatic t_live_ba();
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0; b_in = 8'h5A; #1;
        chk("R5 a_oe dir=0", {7'd0, a_oe}, 8'h01);
        chk("R5 b_oe dir=0", {7'd0, b_oe}, 8'h00);
        chk("R6 live B to A", a_out, 8'h5A);
    endtask

    task automatic t_isolate_store();
        @(negedge clk);
        oe_n = 1'b1; a_in = 8'hA5; b_in = 8'h77;
        pulse(1'b1, 1'b0);
        sel_ab = 1'b1; sel_ba = 1'b1; #1;
        chk("R1 stored while isolated (R10)", b_out, 8'hA5);
        chk("R3 ba untouched by clk_ab", a_out, 8'h00);
        oe_n = 1'b0; dir = 1'b1; #1;
        chk("R7 stored A on B", b_out, 8'hA5);
    endtask

    task automatic t_stored_ba();
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b1; b_in = 8'h96;
        pulse(1'b0, 1'b1);
        chk("R2 capture B while A driven", a_out, 8'h96);
        chk("R3 ab untouched by clk_ba", b_out, 8'hA5);
        b_in = 8'h11; #1;
        chk("R6 stored ignores live B", a_out, 8'h96);
        sel_ba = 1'b0; #1;
        chk("R9 select flips without edge", a_out, 8'h11);
    endtask

    task automatic t_stored_ab();
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'h4D;
        pulse(1'b1, 1'b0);
        chk("R7 stored A after capture (R1)", b_out, 8'h4D);
        a_in = 8'hFF; #1;
        chk("R7 stored ignores live A", b_out, 8'h4D);
    endtask

    task automatic t_store_both();
        @(negedge clk);
        oe_n = 1'b1; a_in = 8'hE1; b_in = 8'h1E; sel_ab = 1'b1; sel_ba = 1'b1;
        pulse(1'b1, 1'b1);
        chk("R1 both same cycle", b_out, 8'hE1);
        chk("R2 both same cycle", a_out, 8'h1E);
    endtask

    task automatic t_reset_indep();
        @(negedge clk);
        rst_ab = 1'b1;
        pulse(1'b1, 1'b0);
        rst_ab = 1'b0; #1;
        chk("R8 ab reset clears", b_out, 8'h00);
        chk("R8 ba kept on ab reset", a_out, 8'h1E);
    endtask

    initial begin
        rst_ab = 1'b1; rst_ba = 1'b1; en_ab = 1'b1; en_ba = 1'b1;
        oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        a_in = '0; b_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_ab = 1'b0; rst_ba = 1'b0; en_ab = 1'b0; en_ba = 1'b0;
        t_reset();
        t_live_ab();
        t_live_ba();
        t_isolate_store();
        t_stored_ba();
        t_stored_ab();
        t_store_both();
        t_reset_indep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule